// File: doc/BRIEF.md
# Display Controller Serial Register Port

This block is the host-facing side of a vacuum fluorescent display controller. A host frames each transaction by pulling an active-low strobe low. It then clocks bytes in on one data line, least significant bit first. The block decodes the opening byte of each frame as a command and handles every later byte in that frame as data. Data bytes are either written into the register space or replaced by bytes the block shifts out on a separate data line. That output line has its own output enable.

The register space holds three things:
- a display memory of eleven digits with two bytes each (0x00 to 0x15); a digit's four nibbles map to its segments 1 to 16 in order;
- a four-bit LED port, active low;
- two read-only sources: a four-bit switch port and a packed key-scan bus that a separate scanner supplies.

A second, independent read port on the display memory lets a refresh engine fetch digit bytes while the host is writing. The block also latches two 4-bit setting fields, display mode and display control, from their commands. The pins are sampled by the system clock, and every output is registered.

Top module: `vfdc_serial_regs`

## Requirements
- R1: The first complete byte after the strobe goes low is a command; every later byte of that frame is data, even if its value looks like a command (a data byte 0xC5 is stored, not decoded).
- R2: If the strobe returns high before all eight bits of a byte have arrived, the partial byte has no effect, and the next frame starts bit alignment afresh with a new command byte.
- R3: Serial data moves least significant bit first in both directions; input bits are taken on the serial clock rising edge.
- R4: Command bits 7:6 = 11 set the write address from bits 4:0. Data-set command (bits 7:6 = 01) bits 1:0 = 00 select display writes. With data-set bit 2 = 0, the address advances by one after each data byte and wraps from 0x15 to 0x00. With bit 2 = 1 it stays fixed.
- R5: An address command carrying a value above 0x15 leaves the write address unchanged.
- R6: Data-set op 01 directs data bytes to the LED port. Byte bits 3:0 drive `led_n[3:0]` (0 = lit) and bits 7:4 are ignored. After reset `led_n` is 4'hF.
- R7: Data-set op 11 makes each following byte of the frame read back as {4'b0000, sw_in}.
- R8: Data-set op 10 makes the following bytes read back `key_bits` one byte at a time, bits 7:0 first; bytes past the last key byte read as 0x00.
- R9: `ser_dout_oe` is high only in the data part of a read frame and is low after reset and once the strobe is high. `ser_dout` changes only following a serial clock falling edge.
- R10: Command bits 7:6 = 00 load `disp_mode` from bits 3:0, and bits 7:6 = 10 load `disp_ctrl` from bits 3:0. Both are zero after reset.
- R11: `disp_rdata` shows the byte at `disp_raddr` one clock later; addresses above 0x15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from host, idles high |
| ser_stb_n | input | 1 | Frame strobe, low during a transaction |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial read data to host |
| ser_dout_oe | output | 1 | Output enable for ser_dout |
| led_n | output | 4 | LED drive, active low |
| sw_in | input | 4 | Switch inputs |
| key_bits | input | 24 | Packed key-scan result, byte 0 in bits 7:0 |
| disp_raddr | input | 5 | Refresh read address |
| disp_rdata | output | 8 | Refresh read data |
| disp_mode | output | 4 | Latched display mode field |
| disp_ctrl | output | 4 | Latched display control field |

## Verification
The bench builds the block with its default sizes: eleven digits of two bytes, a four-bit LED and switch port, and three key bytes. With these sizes the wrap of the write address from 0x15 back to 0x00 takes only three data bytes. A four-byte key read reaches the zero fill past the last key byte. Address values just above the memory top (0x16 and 0x1F) exercise the ignore rule on both sides of the five-bit field.

// File: rtl/vfdc_pkg.sv
package vfdc_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CMD_DMODE = 2'b00,
    CMD_DSET  = 2'b01,
    CMD_DCTRL = 2'b10,
    CMD_ADDR  = 2'b11
  } cmd_kind_e;

  typedef enum logic [1:0] {
    OP_WR_DISP = 2'b00,
    OP_WR_LED  = 2'b01,
    OP_RD_KEY  = 2'b10,
    OP_RD_SW   = 2'b11
  } dset_op_e;

  typedef struct packed {
    dset_op_e op;
    logic     fixed;
  } dset_t;
endpackage

// File: rtl/vfdc_rx.sv
module vfdc_rx
  import vfdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_stb_n,
  input  logic              ser_din,
  output logic              frame_act,
  output logic              sclk_fall,
  output logic              byte_done,
  output logic              byte_is_cmd,
  output logic [BYTE_W-1:0] byte_val,
  output logic [2:0]        bit_idx
);
  logic clk_q, clk_d, stb_q, din_q, first_q;
  logic [2:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              sclk_rise;
  logic [BYTE_W-1:0] sh_next;

  assign sclk_rise = clk_q & ~clk_d;
  assign sclk_fall = ~clk_q & clk_d;
  assign frame_act = ~stb_q;
  assign bit_idx   = cnt_q;
  assign sh_next   = {din_q, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q       <= 1'b1;
      clk_d       <= 1'b1;
      stb_q       <= 1'b1;
      din_q       <= 1'b0;
      first_q     <= 1'b1;
      cnt_q       <= '0;
      sh_q        <= '0;
      byte_done   <= 1'b0;
      byte_is_cmd <= 1'b0;
      byte_val    <= '0;
    end else begin
      clk_q     <= ser_clk;
      clk_d     <= clk_q;
      stb_q     <= ser_stb_n;
      din_q     <= ser_din;
      byte_done <= 1'b0;
      if (stb_q) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (sclk_rise) begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          byte_done   <= 1'b1;
          byte_val    <= sh_next;
          byte_is_cmd <= first_q;
          first_q     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vfdc_dram.sv
module vfdc_dram #(
  parameter int DEPTH = 22,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata <= '0;
    else if (raddr <= LAST) rdata <= mem[raddr];
    else                    rdata <= '0;
  end
endmodule

// File: rtl/vfdc_tx.sv
module vfdc_tx
  import vfdc_pkg::*;
#(
  parameter int KEY_BYTES = 3,
  parameter int SW_W      = 4,
  localparam int IW       = $clog2(KEY_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   byte_adv,
  input  logic                   sel_key,
  input  logic                   rd_active,
  input  logic                   sclk_fall,
  input  logic [2:0]             bit_idx,
  input  logic [KEY_BYTES*8-1:0] key_bits,
  input  logic [SW_W-1:0]        sw_in,
  output logic                   dout
);
  logic [IW-1:0]     idx_q;
  logic [BYTE_W-1:0] cur;

  always_comb begin
    cur = '0;
    if (sel_key) begin
      for (int i = 0; i < KEY_BYTES; i++) begin
        if (idx_q == IW'(i)) cur = key_bits[i*8 +: 8];
      end
    end else begin
      cur = {{(BYTE_W-SW_W){1'b0}}, sw_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      dout  <= 1'b0;
    end else begin
      if (load)
        idx_q <= '0;
      else if (byte_adv && idx_q != IW'(KEY_BYTES))
        idx_q <= idx_q + 1'b1;
      if (sclk_fall && rd_active)
        dout <= cur[bit_idx];
    end
  end
endmodule

// File: rtl/vfdc_serial_regs.sv
module vfdc_serial_regs
  import vfdc_pkg::*;
#(
  parameter int DIGITS          = 11,
  parameter int BYTES_PER_DIGIT = 2,
  parameter int LED_W           = 4,
  parameter int SW_W            = 4,
  parameter int KEY_BYTES       = 3,
  localparam int DEPTH          = DIGITS * BYTES_PER_DIGIT,
  localparam int AW             = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ser_clk,
  input  logic                   ser_stb_n,
  input  logic                   ser_din,
  output logic                   ser_dout,
  output logic                   ser_dout_oe,
  output logic [LED_W-1:0]       led_n,
  input  logic [SW_W-1:0]        sw_in,
  input  logic [KEY_BYTES*8-1:0] key_bits,
  input  logic [AW-1:0]          disp_raddr,
  output logic [BYTE_W-1:0]      disp_rdata,
  output logic [3:0]             disp_mode,
  output logic [3:0]             disp_ctrl
);
  localparam int ADDR_FLD_W          = 5;
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);
  localparam logic [ADDR_FLD_W-1:0] LAST_FLD = ADDR_FLD_W'(DEPTH - 1);

  logic              frame_act, sclk_fall, byte_done, byte_is_cmd;
  logic [BYTE_W-1:0] byte_val;
  logic [2:0]        bit_idx;
  logic              cmd_done, data_done, ram_we, led_we, rd_load;
  logic              rd_active;
  logic [AW-1:0]     waddr;
  dset_t             dset_q;
  cmd_kind_e         cmd_kind;
  logic [ADDR_FLD_W-1:0] addr_fld;

  vfdc_rx u_rx (
    .clk         (clk),
    .rst         (rst),
    .ser_clk     (ser_clk),
    .ser_stb_n   (ser_stb_n),
    .ser_din     (ser_din),
    .frame_act   (frame_act),
    .sclk_fall   (sclk_fall),
    .byte_done   (byte_done),
    .byte_is_cmd (byte_is_cmd),
    .byte_val    (byte_val),
    .bit_idx     (bit_idx)
  );

  assign cmd_kind  = cmd_kind_e'(byte_val[7:6]);
  assign addr_fld  = byte_val[ADDR_FLD_W-1:0];
  assign cmd_done  = byte_done & byte_is_cmd;
  assign data_done = byte_done & ~byte_is_cmd;
  assign ram_we    = data_done & ~rd_active & (dset_q.op == OP_WR_DISP);
  assign led_we    = data_done & ~rd_active & (dset_q.op == OP_WR_LED);
  assign rd_load   = cmd_done & (cmd_kind == CMD_DSET) & byte_val[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_active <= 1'b0;
      dset_q    <= '{op: OP_WR_DISP, fixed: 1'b0};
      waddr     <= '0;
      led_n     <= '1;
      disp_mode <= '0;
      disp_ctrl <= '0;
    end else begin
      if (!frame_act)   rd_active <= 1'b0;
      else if (rd_load) rd_active <= 1'b1;

      if (cmd_done) begin
        unique case (cmd_kind)
          CMD_DMODE: disp_mode <= byte_val[3:0];
          CMD_DCTRL: disp_ctrl <= byte_val[3:0];
          CMD_DSET: begin
            dset_q.op    <= dset_op_e'(byte_val[1:0]);
            dset_q.fixed <= byte_val[2];
          end
          CMD_ADDR: begin
            if (addr_fld <= LAST_FLD) waddr <= addr_fld[AW-1:0];
          end
        endcase
      end

      if (ram_we && !dset_q.fixed)
        waddr <= (waddr == LAST) ? '0 : waddr + 1'b1;

      if (led_we) led_n <= byte_val[LED_W-1:0];
    end
  end

  assign ser_dout_oe = rd_active;

  vfdc_dram #(.DEPTH(DEPTH), .DW(BYTE_W)) u_dram (
    .clk   (clk),
    .rst   (rst),
    .we    (ram_we),
    .waddr (waddr),
    .wdata (byte_val),
    .raddr (disp_raddr),
    .rdata (disp_rdata)
  );

  vfdc_tx #(.KEY_BYTES(KEY_BYTES), .SW_W(SW_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (rd_load),
    .byte_adv  (data_done & rd_active),
    .sel_key   (dset_q.op == OP_RD_KEY),
    .rd_active (rd_active),
    .sclk_fall (sclk_fall),
    .bit_idx   (bit_idx),
    .key_bits  (key_bits),
    .sw_in     (sw_in),
    .dout      (ser_dout)
  );
endmodule

// File: rtl/vfdc_serial_regs_chk.sv
module vfdc_serial_regs_chk #(
  parameter int AW    = 5,
  parameter int DEPTH = 22,
  parameter int LED_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_act,
  input logic             sclk_fall,
  input logic             byte_done,
  input logic             byte_is_cmd,
  input logic             ram_we,
  input logic             led_we,
  input logic [AW-1:0]    waddr,
  input logic [LED_W-1:0] led_n,
  input logic             ser_dout,
  input logic             ser_dout_oe,
  input logic [AW-1:0]    disp_raddr,
  input logic [7:0]       disp_rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R6
  led_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (led_n == '1));

  // R6
  led_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !led_we |=> $stable(led_n));

  // R1
  cmd_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && byte_is_cmd) |-> !ram_we);

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_act |=> !ser_dout_oe);

  // R9
  dout_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(ser_dout));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    waddr <= LAST);

  // R11
  refresh_oob_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_raddr > LAST) |=> (disp_rdata == 8'h00));
endmodule

bind vfdc_serial_regs vfdc_serial_regs_chk #(.AW(AW), .DEPTH(DEPTH), .LED_W(LED_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_act   (frame_act),
  .sclk_fall   (sclk_fall),
  .byte_done   (byte_done),
  .byte_is_cmd (byte_is_cmd),
  .ram_we      (ram_we),
  .led_we      (led_we),
  .waddr       (waddr),
  .led_n       (led_n),
  .ser_dout    (ser_dout),
  .ser_dout_oe (ser_dout_oe),
  .disp_raddr  (disp_raddr),
  .disp_rdata  (disp_rdata)
);

// File: tb/vfdc_serial_regs_tb.sv
module vfdc_serial_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b1, ser_stb_n = 1'b1, ser_din = 1'b0;
  logic        ser_dout, ser_dout_oe;
  logic [3:0]  led_n, sw_in = 4'h0, disp_mode, disp_ctrl;
  logic [23:0] key_bits = 24'h0;
  logic [4:0]  disp_raddr = 5'd0;
  logic [7:0]  disp_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vfdc_serial_regs u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_stb_n(ser_stb_n),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
    .led_n(led_n), .sw_in(sw_in), .key_bits(key_bits),
    .disp_raddr(disp_raddr), .disp_rdata(disp_rdata),
    .disp_mode(disp_mode), .disp_ctrl(disp_ctrl)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame_on;
    ser_stb_n = 1'b0; tick(4);
  endtask

  task automatic frame_off;
    ser_stb_n = 1'b1; tick(6);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      ser_clk = 1'b0; ser_din = b[i]; tick(4);
      ser_clk = 1'b1; tick(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      ser_clk = 1'b0; tick(4);
      b[i] = ser_dout;
      ser_clk = 1'b1; tick(4);
    end
  endtask

  task automatic cmd_frame(input logic [7:0] c);
    frame_on; send_byte(c); frame_off;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] d);
    disp_raddr = a; tick(2); d = disp_rdata;
  endtask

  task automatic t_reset;
    chk("R6 reset led_n", led_n, 4'hF);
    chk("R9 reset oe", ser_dout_oe, 1'b0);
    chk("R10 reset mode", disp_mode, 4'h0);
    chk("R10 reset ctrl", disp_ctrl, 4'h0);
  endtask

  task automatic t_write_auto;
    logic [7:0] d;
    cmd_frame(8'h40);
    frame_on; send_byte(8'hC2); send_byte(8'h12); send_byte(8'hC5); send_byte(8'h81); frame_off;
    peek(5'h02, d); chk("R3 lsb-first write 0x02", d, 8'h12);
    peek(5'h03, d); chk("R1 data byte not decoded 0x03", d, 8'hC5);
    peek(5'h04, d); chk("R4 auto increment 0x04", d, 8'h81);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    frame_on; send_byte(8'hD4); send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC); frame_off;
    peek(5'h14, d); chk("R4 write 0x14", d, 8'hAA);
    peek(5'h15, d); chk("R4 write 0x15", d, 8'hBB);
    peek(5'h00, d); chk("R4 wrap to 0x00", d, 8'hCC);
  endtask

  task automatic t_fixed;
    logic [7:0] d;
    frame_on; send_byte(8'hC8); send_byte(8'h5A); frame_off;
    cmd_frame(8'h44);
    frame_on; send_byte(8'hC7); send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); frame_off;
    peek(5'h07, d); chk("R4 fixed addr last byte", d, 8'h33);
    peek(5'h08, d); chk("R4 fixed addr neighbour untouched", d, 8'h5A);
    cmd_frame(8'h40);
  endtask

  task automatic t_addr_ignore;
    logic [7:0] d;
    cmd_frame(8'hC5);
    frame_on; send_byte(8'hDF); send_byte(8'h3C); frame_off;
    peek(5'h05, d); chk("R5 addr 0x1F ignored", d, 8'h3C);
    frame_on; send_byte(8'hD6); send_byte(8'h4D); frame_off;
    peek(5'h06, d); chk("R5 addr 0x16 ignored", d, 8'h4D);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    frame_on; send_byte(8'hC9); send_byte(8'h77); send_bits(8'h00, 4); frame_off;
    peek(5'h09, d); chk("R2 partial data byte discarded", d, 8'h77);
    frame_on; send_bits(8'hFF, 5); frame_off;
    frame_on; send_byte(8'hC9); send_byte(8'h66); frame_off;
    peek(5'h09, d); chk("R2 realign after partial command", d, 8'h66);
  endtask

  task automatic t_led;
    frame_on; send_byte(8'h41); send_byte(8'hF5); frame_off;
    chk("R6 led upper bits ignored", led_n, 4'h5);
    frame_on; send_byte(8'h41); send_bits(8'h00, 4); frame_off;
    chk("R2 partial led byte discarded", led_n, 4'h5);
    frame_on; send_byte(8'h41); send_byte(8'h0A); frame_off;
    chk("R6 led second value", led_n, 4'hA);
  endtask

  task automatic t_sw;
    logic [7:0] d;
    sw_in = 4'h9;
    frame_on; send_byte(8'h43);
    recv_byte(d); chk("R7 switch read", d, 8'h09);
    chk("R9 oe during read", ser_dout_oe, 1'b1);
    sw_in = 4'h6;
    recv_byte(d); chk("R7 switch second read", d, 8'h06);
    frame_off;
    chk("R9 oe after frame", ser_dout_oe, 1'b0);
  endtask

  task automatic t_key;
    logic [7:0] d;
    key_bits = 24'hC3_5A_81;
    frame_on; send_byte(8'h42);
    recv_byte(d); chk("R8 key byte 0", d, 8'h81);
    recv_byte(d); chk("R8 key byte 1", d, 8'h5A);
    recv_byte(d); chk("R8 key byte 2", d, 8'hC3);
    recv_byte(d); chk("R8 key past end", d, 8'h00);
    frame_off;
  endtask

  task automatic t_mode;
    cmd_frame(8'h07);
    chk("R10 display mode", disp_mode, 4'h7);
    cmd_frame(8'h8B);
    chk("R10 display ctrl", disp_ctrl, 4'hB);
    chk("R10 mode unchanged by ctrl", disp_mode, 4'h7);
  endtask

  task automatic t_refresh;
    logic [7:0] d;
    peek(5'h1F, d); chk("R11 out of range reads zero", d, 8'h00);
    peek(5'h15, d); chk("R11 refresh top byte", d, 8'hBB);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    t_reset;
    t_write_auto;
    t_wrap;
    t_fixed;
    t_addr_ignore;
    t_abort;
    t_led;
    t_sw;
    t_key;
    t_mode;
    t_refresh;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule